// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes commands written over an asynchronous, SRAM-style flash bus (active-low chip enable, write enable and output enable, plus address and data) and controls the read mode of a NOR-style flash model. It accepts single-write commands that select what a read returns: array data, status, configuration or query. It also accepts two-write sequences that launch a program or a block erase on an internal write engine through a start pulse.

The controller keeps a status register. It handles suspending and resuming a running job. While an erase is suspended, it permits a program to run. The flash cells, the engine's algorithms and its timing lie outside the block. The engine is seen only through a start pulse, a done pulse, a suspend request and acknowledge, and a resume pulse.

The bus inputs are sampled with the block clock. A write is recognised while chip enable and write enable are low and output enable is high. It takes effect in the cycle in which that condition ends. The address and data used are those sampled in the last cycle the condition held.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `status_o` is 80H, `rd_src_o` selects array data, and `eng_start_o`, `eng_resume_o` and `eng_susp_req_o` are low.
- R2: A write is taken only while `ce_ni`=0, `we_ni`=0 and `oe_ni`=1. It commits when that condition ends. It uses the address and data sampled in the last cycle the condition held. Any other combination has no effect.
- R3: Command byte (data bits 7:0) FFH selects array reads, 70H status, 90H configuration and 98H query. `rd_src_o` encodes these as 0, 1, 2 and 3 respectively.
- R4: 40H followed by any second write pulses `eng_start_o` for one cycle. That pulse comes with `eng_op_o`=0 and with the second write's address and data. Status bit 7 (ready) then reads 0.
- R5: 20H followed by a second write of D0H pulses `eng_start_o` with `eng_op_o`=1 and the second write's address.
- R6: 20H followed by any byte other than D0H starts nothing. It sets status bits 5 (erase error) and 4 (program error) and selects status reads.
- R7: While a job runs (ready=0), `rd_src_o` reports status whatever mode was chosen. Commands other than B0H are ignored.
- R8: An `eng_done_i` pulse sets ready. Reads stay on status until FFH is written.
- R9: Bits 5 and 4 stay set across other commands until 50H clears them. 50H leaves the read mode unchanged.
- R10: B0H during a job raises `eng_susp_req_o` and holds it until `eng_susp_ack_i`. The acknowledge sets ready together with bit 6 for an erase or bit 2 for a program.
- R11: D0H while suspended pulses `eng_resume_o`. It clears the suspended bit and clears ready.
- R12: While an erase is suspended, 20H is ignored. A program may still start and run; bit 6 stays set during it and after it, and B0H is ignored during it. While a program is suspended, 40H and 20H are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data; bits 7:0 carry the command |
| rd_src_o | output | 2 | Read source: 0 array, 1 status, 2 configuration, 3 query |
| status_o | output | 8 | Status register |
| eng_start_o | output | 1 | One-cycle job start pulse |
| eng_op_o | output | 1 | Job kind: 0 program, 1 erase |
| eng_addr_o | output | AW | Job address |
| eng_data_o | output | DW | Program data |
| eng_done_i | input | 1 | Job completion pulse |
| eng_susp_req_o | output | 1 | Suspend request, held until acknowledged |
| eng_susp_ack_i | input | 1 | Suspend acknowledge |
| eng_resume_o | output | 1 | One-cycle resume pulse |

## Verification
The bench builds the block with its defaults of a 20-bit address and a 16-bit data word. That is wide enough to show that the full second-write word reaches the engine, while the command byte uses only the low eight bits. The engine is a stub driven from bench tasks, so done and acknowledge pulses can be placed in any state. This brings within reach a program nested in a suspended erase, a resume after that nested program, and the ignoring of commands that each suspended state rejects.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_CONFIG = 2'd2,
    SRC_QUERY  = 2'd3
  } rd_src_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PSETUP, ST_ESETUP, ST_RUN, ST_SWAIT
  } ctl_state_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_CONFIG  = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam logic OP_PROG  = 1'b0;
  localparam logic OP_ERASE = 1'b1;
endpackage

// File: rtl/flash_bus_wr.sv
module flash_bus_wr #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic act, act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  // commit on the cycle the write condition ends
  assign wr_o   = act_q & ~act;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       esusp_i,
  input  logic       psusp_i,
  input  logic       err_set_i,
  input  logic       err_clr_i,
  output logic [7:0] status_o
);
  logic eerr_q, perr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
    end else if (err_set_i) begin
      eerr_q <= 1'b1;
      perr_q <= 1'b1;
    end else if (err_clr_i) begin
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
    end
  end

  assign status_o = {~run_i, esusp_i, eerr_q, perr_q, 1'b0, psusp_i, 2'b00};
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          done_i,
  input  logic          susp_ack_i,
  output rd_src_e       mode_o,
  output logic          run_o,
  output logic          esusp_o,
  output logic          psusp_o,
  output logic          err_set_o,
  output logic          err_clr_o,
  output logic          start_o,
  output logic          op_o,
  output logic [AW-1:0] job_addr_o,
  output logic [DW-1:0] job_data_o,
  output logic          susp_req_o,
  output logic          resume_o
);
  ctl_state_e    state_q;
  rd_src_e       mode_q;
  logic          esusp_q, psusp_q, op_q, start_q, resume_q;
  logic [AW-1:0] jaddr_q;
  logic [DW-1:0] jdata_q;
  logic [7:0]    cmd;
  logic          nested;

  assign cmd    = data_i[7:0];
  assign nested = esusp_q & (op_q == OP_PROG);

  assign err_set_o = wr_i & (state_q == ST_ESETUP) & (cmd != CMD_CONFIRM);
  assign err_clr_o = wr_i & (state_q == ST_IDLE) & (cmd == CMD_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= SRC_ARRAY;
      esusp_q  <= 1'b0;
      psusp_q  <= 1'b0;
      op_q     <= OP_PROG;
      start_q  <= 1'b0;
      resume_q <= 1'b0;
      jaddr_q  <= '0;
      jdata_q  <= '0;
    end else begin
      start_q  <= 1'b0;
      resume_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (wr_i) begin
          unique case (cmd)
            CMD_ARRAY:   mode_q <= SRC_ARRAY;
            CMD_STATUS:  mode_q <= SRC_STATUS;
            CMD_CONFIG:  mode_q <= SRC_CONFIG;
            CMD_QUERY:   mode_q <= SRC_QUERY;
            CMD_PROGRAM: if (!psusp_q) state_q <= ST_PSETUP;
            CMD_ERASE:   if (!psusp_q && !esusp_q) state_q <= ST_ESETUP;
            CMD_CONFIRM: begin
              if (psusp_q) begin
                psusp_q  <= 1'b0;
                op_q     <= OP_PROG;
                resume_q <= 1'b1;
                state_q  <= ST_RUN;
                mode_q   <= SRC_STATUS;
              end else if (esusp_q) begin
                esusp_q  <= 1'b0;
                op_q     <= OP_ERASE;
                resume_q <= 1'b1;
                state_q  <= ST_RUN;
                mode_q   <= SRC_STATUS;
              end
            end
            default: ;
          endcase
        end
        ST_PSETUP: if (wr_i) begin
          start_q <= 1'b1;
          op_q    <= OP_PROG;
          jaddr_q <= addr_i;
          jdata_q <= data_i;
          state_q <= ST_RUN;
          mode_q  <= SRC_STATUS;
        end
        ST_ESETUP: if (wr_i) begin
          mode_q <= SRC_STATUS;
          if (cmd == CMD_CONFIRM) begin
            start_q <= 1'b1;
            op_q    <= OP_ERASE;
            jaddr_q <= addr_i;
            state_q <= ST_RUN;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (done_i) begin
            state_q <= ST_IDLE;
            mode_q  <= SRC_STATUS;
          end else if (wr_i && cmd == CMD_SUSPEND && !nested) begin
            state_q <= ST_SWAIT;
          end
        end
        ST_SWAIT: begin
          if (done_i) begin
            state_q <= ST_IDLE;
            mode_q  <= SRC_STATUS;
          end else if (susp_ack_i) begin
            state_q <= ST_IDLE;
            mode_q  <= SRC_STATUS;
            if (op_q == OP_ERASE) esusp_q <= 1'b1;
            else                  psusp_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign run_o      = (state_q == ST_RUN) | (state_q == ST_SWAIT);
  assign esusp_o    = esusp_q;
  assign psusp_o    = psusp_q;
  assign start_o    = start_q;
  assign op_o       = op_q;
  assign job_addr_o = jaddr_q;
  assign job_data_o = jdata_q;
  assign susp_req_o = (state_q == ST_SWAIT);
  assign resume_o   = resume_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [1:0]    rd_src_o,
  output logic [7:0]    status_o,
  output logic          eng_start_o,
  output logic          eng_op_o,
  output logic [AW-1:0] eng_addr_o,
  output logic [DW-1:0] eng_data_o,
  input  logic          eng_done_i,
  output logic          eng_susp_req_o,
  input  logic          eng_susp_ack_i,
  output logic          eng_resume_o
);
  logic          wr;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  rd_src_e       mode;
  logic          run, esusp, psusp, err_set, err_clr;

  flash_bus_wr #(.AW(AW), .DW(DW)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_o(wr), .addr_o(wr_addr), .data_o(wr_data)
  );

  flash_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .wr_i(wr), .addr_i(wr_addr), .data_i(wr_data),
    .done_i(eng_done_i), .susp_ack_i(eng_susp_ack_i),
    .mode_o(mode), .run_o(run), .esusp_o(esusp), .psusp_o(psusp),
    .err_set_o(err_set), .err_clr_o(err_clr),
    .start_o(eng_start_o), .op_o(eng_op_o),
    .job_addr_o(eng_addr_o), .job_data_o(eng_data_o),
    .susp_req_o(eng_susp_req_o), .resume_o(eng_resume_o)
  );

  flash_status_reg u_sr (
    .clk_i, .rst_ni, .run_i(run), .esusp_i(esusp), .psusp_i(psusp),
    .err_set_i(err_set), .err_clr_i(err_clr), .status_o
  );

  // busy forces status reads
  assign rd_src_o = run ? SRC_STATUS : mode;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          we_ni,
  input logic          oe_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] data_i,
  input logic [1:0]    rd_src_o,
  input logic [7:0]    status_o,
  input logic          eng_start_o,
  input logic          eng_op_o,
  input logic [AW-1:0] eng_addr_o,
  input logic [DW-1:0] eng_data_o,
  input logic          eng_done_i,
  input logic          eng_susp_req_o,
  input logic          eng_susp_ack_i,
  input logic          eng_resume_o
);
  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> !status_o[7]);
  // R4
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  // R7
  busy_reads_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] |-> rd_src_o == 2'd1);
  // R10
  susp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_susp_req_o && !eng_susp_ack_i && !eng_done_i) |=> eng_susp_req_o);
  // R10
  susp_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> $past(eng_susp_ack_i));
  // R11
  resume_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_resume_o |-> !status_o[7] && !status_o[2]);
  // R12
  one_susp_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[6] && status_o[2]));
  // R1
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |-> !eng_susp_req_o);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic done = 1'b0, ack = 1'b0;
  logic [1:0] rd_src;
  logic [7:0] status;
  logic start, op, susp_req, resume;
  logic [AW-1:0] eaddr;
  logic [DW-1:0] edata;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_status = 8'h80;
  logic [1:0] exp_src = 2'd0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW)) u_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .rd_src_o(rd_src), .status_o(status),
    .eng_start_o(start), .eng_op_o(op), .eng_addr_o(eaddr), .eng_data_o(edata),
    .eng_done_i(done), .eng_susp_req_o(susp_req), .eng_susp_ack_i(ack),
    .eng_resume_o(resume)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    #1;
    if (model_on) begin
      check(status == exp_status, "R8 model status", status, exp_status);
      check(rd_src == exp_src, "R3 model rd_src", rd_src, exp_src);
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; data = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status == 8'h80, "R1 status", status, 8'h80);
    check(rd_src == 2'd0, "R1 rd_src", rd_src, 0);
    check(!start && !resume && !susp_req, "R1 engine outputs", {start, resume, susp_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1'b1;

    // R3 read mode selection
    bus_write(0, 16'h0090); exp_src = 2'd2;
    check(rd_src == 2'd2, "R3 config", rd_src, 2);
    bus_write(0, 16'h0098); exp_src = 2'd3;
    bus_write(0, 16'h0070); exp_src = 2'd1;
    check(rd_src == 2'd1, "R3 status", rd_src, 1);
    bus_write(0, 16'h00FF); exp_src = 2'd0;

    // R2 oe low or ce high means no write
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; data = 16'h0070;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    check(rd_src == 2'd0, "R2 oe low ignored", rd_src, 0);
    ce_n = 1'b1; we_n = 1'b0; data = 16'h0090;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    check(rd_src == 2'd0, "R2 ce high ignored", rd_src, 0);

    // R4 program, last sampled address wins (R2)
    bus_write(0, 16'h0040);
    ce_n = 1'b0; we_n = 1'b0; addr = 20'h01111; data = 16'h1111;
    @(negedge clk);
    addr = 20'h01234; data = 16'hABCD;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    exp_status = 8'h00; exp_src = 2'd1;
    check(start && op == 1'b0, "R4 start program", {start, op}, 2'b10);
    check(eaddr == 20'h01234, "R2 captured address", eaddr, 20'h01234);
    check(edata == 16'hABCD, "R4 program data", edata, 16'hABCD);
    @(negedge clk);
    check(!start, "R4 single pulse", start, 0);
    // R7 commands while busy ignored
    bus_write(0, 16'h00FF);
    bus_write(0, 16'h0040);
    check(!start && rd_src == 2'd1, "R7 busy ignores", {start, rd_src}, 1);

    // R8 completion keeps status reads
    pulse_done(); exp_status = 8'h80; exp_src = 2'd1;
    check(rd_src == 2'd1, "R8 status after done", rd_src, 1);
    bus_write(0, 16'h00FF); exp_src = 2'd0;

    // R6 bad erase confirm
    bus_write(0, 16'h0020);
    bus_write(20'h40000, 16'h0055); exp_status = 8'hB0; exp_src = 2'd1;
    check(!start, "R6 no start", start, 0);
    check(status == 8'hB0, "R6 error bits", status, 8'hB0);
    // R9 errors persist, then clear
    bus_write(0, 16'h00FF); exp_src = 2'd0;
    check(status == 8'hB0, "R9 errors persist", status, 8'hB0);
    bus_write(0, 16'h0050); exp_status = 8'h80;
    check(status == 8'h80 && rd_src == 2'd0, "R9 clear keeps mode", {status, 6'd0, rd_src}, 16'h8000);

    // R5 erase
    bus_write(0, 16'h0020);
    bus_write(20'h40000, 16'h00D0); exp_status = 8'h00; exp_src = 2'd1;
    check(start && op && eaddr == 20'h40000, "R5 start erase", {start, op}, 2'b11);

    // R10 suspend erase
    bus_write(0, 16'h00B0);
    check(susp_req, "R10 request raised", susp_req, 1);
    repeat (3) @(negedge clk);
    check(susp_req && status == 8'h00, "R10 request held", susp_req, 1);
    pulse_ack(); exp_status = 8'hC0;
    check(!susp_req && status == 8'hC0, "R10 erase suspended", status, 8'hC0);

    // R12 erase ignored during erase suspend
    bus_write(0, 16'h0020);
    check(!start, "R12 erase ignored", start, 0);
    bus_write(0, 16'h00FF); exp_src = 2'd0;
    check(status == 8'hC0 && rd_src == 2'd0, "R12 no setup entered", status, 8'hC0);
    // R12 program during erase suspend
    bus_write(0, 16'h0040);
    bus_write(20'h00010, 16'h5A5A); exp_status = 8'h40; exp_src = 2'd1;
    check(start && !op && edata == 16'h5A5A, "R12 nested program", {start, op}, 2'b10);
    bus_write(0, 16'h00B0);
    check(!susp_req, "R12 nested suspend ignored", susp_req, 0);
    pulse_done(); exp_status = 8'hC0;
    check(status == 8'hC0, "R12 erase still suspended", status, 8'hC0);

    // R11 resume erase
    bus_write(0, 16'h00D0); exp_status = 8'h00;
    check(resume, "R11 resume pulse", resume, 1);
    @(negedge clk);
    check(!resume, "R11 resume single", resume, 0);
    pulse_done(); exp_status = 8'h80;

    // R10 program suspend, R12 commands ignored while it is held
    bus_write(0, 16'h0040);
    bus_write(20'h00020, 16'h0F0F); exp_status = 8'h00;
    bus_write(0, 16'h00B0);
    pulse_ack(); exp_status = 8'h84;
    check(status == 8'h84, "R10 program suspended", status, 8'h84);
    bus_write(0, 16'h0040);
    bus_write(0, 16'h00FF); exp_src = 2'd0;
    check(!start && rd_src == 2'd0, "R12 program ignored", {start, rd_src}, 0);
    bus_write(0, 16'h00D0); exp_status = 8'h00; exp_src = 2'd1;
    check(resume && status == 8'h00, "R11 resume program", status, 0);
    pulse_done(); exp_status = 8'h80;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule